// File: doc/BRIEF.md
# Multithreaded delay-slot fetch sequencer

This block hands out fetch addresses for a small in-order pipeline that runs several hardware threads on an architecture with one branch delay slot. Each thread owns a chain of three program counters: current, next and next-next. It also owns a delay-slot record that holds a redirect target until the delay-slot instruction has been issued. When a stage asks the sequencer to place an instruction for a thread, the block answers in the same cycle. The answer gives the fetch address, the following two sequential addresses, a predicted target and a per-thread sequence number. The class of the instruction arrives with the request, since decode and prediction are done elsewhere. From that class the block may raise a squash request, latch a delayed redirect, or block the requesting stage until a return address has been resolved.

Squash redirects from later stages enter on several ports at once. For each thread, the oldest redirect of the cycle wins: the lowest sequence number, and the lowest port index on a tie. The winner reloads the thread's program-counter chain and drops any delayed redirect still waiting. If the thread was blocked waiting for its return, the winner also releases the blocked stage.

Each thread runs a small state machine. The states are TH_IDLE (inactive), TH_RUN (sequencing) and TH_BLOCKED (waiting on a return). Its transitions are:
- activate: any state to TH_RUN.
- deactivate: any state to TH_IDLE.
- return-block: TH_RUN to TH_BLOCKED, on a return that is not predicted taken.
- squash-release: TH_BLOCKED to TH_RUN, on an accepted squash.

The delay-slot record is a second machine with three states:
- DS_NONE to DS_PEND, when a delayed-redirect branch is sequenced.
- DS_PEND to DS_ARMED, when the delay-slot instruction is sequenced.
- DS_ARMED to DS_NONE, when the next instruction is fetched from the target.
- Any state to DS_NONE, on an accepted squash, an activate or a deactivate.

Top module: `fseq_core`

## Requirements
- R1: After reset every thread is inactive, so requests for either thread do not complete, and no squash or block is raised.
- R2: A completed request for a thread returns fetch address A (the thread's current PC), next address A+4, next-next address A+8 and predicted target A+8. It also returns that thread's sequence number, which starts at 0 after reset and rises by one per completed request. The thread's PC then advances by 4. Threads sequence independently.
- R3: A control instruction predicted taken (seq_pred_taken=1, including a predicted-taken return) raises sq_out_valid with sq_out_seq equal to its own number plus one and sq_out_tgt equal to seq_pred_tgt. After one further instruction from that thread (the delay slot), fetch continues at seq_pred_tgt.
- R4: Any other not-taken control instruction that is neither a return nor a conditional-delay-slot branch raises no squash. After one delay slot it redirects fetch to its own address plus 8.
- R5: A conditional-delay-slot control instruction predicted not taken (seq_cond_ds=1, not a return) raises sq_out_valid with sq_out_seq equal to its own number and sq_out_tgt equal to its address plus 8. It leaves the delay-slot record unchanged.
- R6: A request with seq_is_ctl=0 raises no squash and no block, and leaves the delay-slot record unchanged, whatever its other class flags are.
- R7: A return that is not predicted taken completes, raises blk_valid with blk_stage equal to seq_stage, and puts the thread in TH_BLOCKED. While the thread is blocked its requests do not complete and consume no sequence number.
- R8: An accepted squash reloads the thread's chain with target T, T+4 and T+8, and discards any pending or armed delayed redirect.
- R9: Among squash ports naming the same thread in one cycle, the one with the lowest sequence number wins, and on equal numbers the lower port index wins. Different threads are handled independently.
- R10: An accepted squash on a thread in TH_BLOCKED raises bit t of unblk_valid in that cycle, with that thread's unblk_stage field equal to the recorded stage, and returns the thread to TH_RUN.
- R11: When a request and an accepted squash hit the same thread in one cycle, the response uses the pre-squash PC and the squash target decides the next fetch. If the request is a blocking return, the block is released in the same cycle, with unblk_stage equal to seq_stage.
- R12: Activate loads the chain from act_pc and enters TH_RUN with the delay-slot record cleared. Deactivate enters TH_IDLE, clears the record and the blocked-stage index, and stops the thread's requests from completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_valid | input | 1 | Sequencing request |
| seq_tid | input | TW | Thread of the request |
| seq_stage | input | SW | Index of the requesting stage |
| seq_is_ctl | input | 1 | Instruction is a control transfer |
| seq_is_ret | input | 1 | Instruction is a return |
| seq_cond_ds | input | 1 | Conditional-delay-slot branch |
| seq_pred_taken | input | 1 | Predicted taken |
| seq_pred_tgt | input | AW | Predicted target |
| rsp_done | output | 1 | Request completed (0 means stall) |
| rsp_addr | output | AW | Fetch address |
| rsp_npc | output | AW | Fetch address + 4 |
| rsp_nnpc | output | AW | Fetch address + 8 |
| rsp_ptgt | output | AW | Default predicted target |
| rsp_seq | output | QW | Sequence number given |
| sq_out_valid | output | 1 | Squash request raised |
| sq_out_seq | output | QW | Squash everything younger than this |
| sq_out_tgt | output | AW | Redirect address of the squash |
| blk_valid | output | 1 | Block the requesting stage |
| blk_stage | output | SW | Stage to block |
| sqi_valid | input | NSQ | Incoming squash per port |
| sqi_tid | input | NSQ*TW | Thread per port |
| sqi_seq | input | NSQ*QW | Sequence number per port |
| sqi_tgt | input | NSQ*AW | Redirect target per port |
| unblk_valid | output | NT | Release a stage, per thread |
| unblk_stage | output | NT*SW | Stage released, per thread |
| act_valid | input | 1 | Activate a thread |
| act_tid | input | TW | Thread to activate |
| act_pc | input | AW | Start address |
| deact_valid | input | 1 | Deactivate a thread |
| deact_tid | input | TW | Thread to deactivate |

## Verification
Three pairs of functions can fall on the same thread in the same cycle:
- Two squash ports against each other. The bench drives both ports with a younger/older pair, an equal pair and an older/younger pair. It judges the winner by the address of the next fetch.
- A sequencing request against an incoming squash. The bench checks that the response still carries the old PC and that the following fetch lands on the squash target.
- A blocking return against an incoming squash. The bench checks that blk_valid and unblk_valid rise together with the same stage, and that the thread keeps fetching in the next cycle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        TH_IDLE,
        TH_RUN,
        TH_BLOCKED
    } th_state_e;

    typedef enum logic [1:0] {
        DS_NONE,
        DS_PEND,
        DS_ARMED
    } ds_state_e;

    typedef enum logic [2:0] {
        CT_NONE,
        CT_RET_BLOCK,
        CT_COND_SKIP,
        CT_NT_PLAIN,
        CT_TAKEN
    } ctl_class_e;

    // taken wins over every other flag; return beats conditional slot
    function automatic ctl_class_e classify(input logic is_ctl, input logic is_ret,
                                            input logic cond_ds, input logic taken);
        if (!is_ctl)      return CT_NONE;
        else if (taken)   return CT_TAKEN;
        else if (is_ret)  return CT_RET_BLOCK;
        else if (cond_ds) return CT_COND_SKIP;
        else              return CT_NT_PLAIN;
    endfunction

endpackage

// File: rtl/fseq_squash_filter.sv
module fseq_squash_filter #(
    parameter int NT  = 2,
    parameter int NSQ = 2,
    parameter int TW  = 1,
    parameter int QW  = 16,
    parameter int AW  = 32
) (
    input  logic [NSQ-1:0]    sqi_valid,
    input  logic [NSQ*TW-1:0] sqi_tid,
    input  logic [NSQ*QW-1:0] sqi_seq,
    input  logic [NSQ*AW-1:0] sqi_tgt,
    output logic [NT-1:0]     acc_valid,
    output logic [NT*AW-1:0]  acc_tgt
);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic          seen;
        logic [QW-1:0] best;
        logic [AW-1:0] tgt;

        always_comb begin
            seen = 1'b0;
            best = '0;
            tgt  = '0;
            for (int p = 0; p < NSQ; p++) begin
                if (sqi_valid[p] && (sqi_tid[p*TW +: TW] == TW'(t))) begin
                    // a later port only wins when strictly older
                    if (!seen || (sqi_seq[p*QW +: QW] < best)) begin
                        seen = 1'b1;
                        best = sqi_seq[p*QW +: QW];
                        tgt  = sqi_tgt[p*AW +: AW];
                    end
                end
            end
        end

        assign acc_valid[t]          = seen;
        assign acc_tgt[t*AW +: AW]   = tgt;
    end

endmodule

// File: rtl/fseq_thread.sv
module fseq_thread
    import fseq_pkg::*;
#(
    parameter int AW  = 32,
    parameter int QW  = 16,
    parameter int SW  = 3,
    parameter int ISZ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  ctl_class_e    cls,
    input  logic [SW-1:0] stage,
    input  logic [AW-1:0] ptgt_in,
    input  logic          act,
    input  logic [AW-1:0] act_pc,
    input  logic          deact,
    input  logic          sq_acc,
    input  logic [AW-1:0] sq_tgt,
    output logic          run,
    output logic [AW-1:0] eff_pc,
    output logic [QW-1:0] seq_no,
    output logic          unblk,
    output logic [SW-1:0] unblk_stage
);

    localparam logic [AW-1:0] STEP1 = AW'(ISZ);
    localparam logic [AW-1:0] STEP2 = AW'(2 * ISZ);
    localparam logic [AW-1:0] STEP3 = AW'(3 * ISZ);

    th_state_e     st_q, st_d;
    ds_state_e     ds_q, ds_d;
    logic [AW-1:0] pc_q, pc_d, npc_q, npc_d, nnpc_q, nnpc_d, dtgt_q, dtgt_d;
    logic [QW-1:0] seq_q, seq_d;
    logic [SW-1:0] bstage_q, bstage_d;
    logic          fire;

    assign fire = go && (st_q == TH_RUN);

    // next-state process
    always_comb begin
        st_d     = st_q;
        ds_d     = ds_q;
        pc_d     = pc_q;
        npc_d    = npc_q;
        nnpc_d   = nnpc_q;
        dtgt_d   = dtgt_q;
        seq_d    = seq_q;
        bstage_d = bstage_q;
        unique case (st_q)
            TH_IDLE, TH_BLOCKED: ;
            TH_RUN: begin
                if (go) begin
                    seq_d = seq_q + 1'b1;
                    if (ds_q == DS_ARMED) begin
                        pc_d   = dtgt_q + STEP1;
                        npc_d  = dtgt_q + STEP2;
                        nnpc_d = dtgt_q + STEP3;
                        ds_d   = DS_NONE;
                    end else begin
                        pc_d   = npc_q;
                        npc_d  = nnpc_q;
                        nnpc_d = nnpc_q + STEP1;
                        if (ds_q == DS_PEND) ds_d = DS_ARMED;
                    end
                    unique case (cls)
                        CT_TAKEN: begin
                            ds_d   = DS_PEND;
                            dtgt_d = ptgt_in;
                        end
                        CT_NT_PLAIN: begin
                            ds_d   = DS_PEND;
                            dtgt_d = eff_pc + STEP2;
                        end
                        CT_RET_BLOCK: begin
                            st_d     = TH_BLOCKED;
                            bstage_d = stage;
                        end
                        CT_NONE, CT_COND_SKIP: ;
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase
        if (sq_acc) begin
            pc_d   = sq_tgt;
            npc_d  = sq_tgt + STEP1;
            nnpc_d = sq_tgt + STEP2;
            ds_d   = DS_NONE;
            if (st_q != TH_IDLE) st_d = TH_RUN;
        end
        if (act) begin
            pc_d     = act_pc;
            npc_d    = act_pc + STEP1;
            nnpc_d   = act_pc + STEP2;
            ds_d     = DS_NONE;
            st_d     = TH_RUN;
            bstage_d = '0;
        end
        if (deact) begin
            st_d     = TH_IDLE;
            ds_d     = DS_NONE;
            bstage_d = '0;
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= TH_IDLE;
            ds_q     <= DS_NONE;
            pc_q     <= '0;
            npc_q    <= STEP1;
            nnpc_q   <= STEP2;
            dtgt_q   <= '0;
            seq_q    <= '0;
            bstage_q <= '0;
        end else begin
            st_q     <= st_d;
            ds_q     <= ds_d;
            pc_q     <= pc_d;
            npc_q    <= npc_d;
            nnpc_q   <= nnpc_d;
            dtgt_q   <= dtgt_d;
            seq_q    <= seq_d;
            bstage_q <= bstage_d;
        end
    end

    // output process
    always_comb begin
        run         = (st_q == TH_RUN);
        eff_pc      = (ds_q == DS_ARMED) ? dtgt_q : pc_q;
        seq_no      = seq_q;
        unblk       = 1'b0;
        unblk_stage = '0;
        if (sq_acc && !act && !deact) begin
            unique case (st_q)
                TH_BLOCKED: begin
                    unblk       = 1'b1;
                    unblk_stage = bstage_q;
                end
                TH_RUN: begin
                    unblk       = fire && (cls == CT_RET_BLOCK);
                    unblk_stage = unblk ? stage : '0;
                end
                TH_IDLE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fseq_core.sv
module fseq_core
    import fseq_pkg::*;
#(
    parameter int AW  = 32,
    parameter int QW  = 16,
    parameter int SW  = 3,
    parameter int NT  = 2,
    parameter int NSQ = 2,
    parameter int ISZ = 4,
    parameter int TW  = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_valid,
    input  logic [TW-1:0]     seq_tid,
    input  logic [SW-1:0]     seq_stage,
    input  logic              seq_is_ctl,
    input  logic              seq_is_ret,
    input  logic              seq_cond_ds,
    input  logic              seq_pred_taken,
    input  logic [AW-1:0]     seq_pred_tgt,
    output logic              rsp_done,
    output logic [AW-1:0]     rsp_addr,
    output logic [AW-1:0]     rsp_npc,
    output logic [AW-1:0]     rsp_nnpc,
    output logic [AW-1:0]     rsp_ptgt,
    output logic [QW-1:0]     rsp_seq,
    output logic              sq_out_valid,
    output logic [QW-1:0]     sq_out_seq,
    output logic [AW-1:0]     sq_out_tgt,
    output logic              blk_valid,
    output logic [SW-1:0]     blk_stage,
    input  logic [NSQ-1:0]    sqi_valid,
    input  logic [NSQ*TW-1:0] sqi_tid,
    input  logic [NSQ*QW-1:0] sqi_seq,
    input  logic [NSQ*AW-1:0] sqi_tgt,
    output logic [NT-1:0]     unblk_valid,
    output logic [NT*SW-1:0]  unblk_stage,
    input  logic              act_valid,
    input  logic [TW-1:0]     act_tid,
    input  logic [AW-1:0]     act_pc,
    input  logic              deact_valid,
    input  logic [TW-1:0]     deact_tid
);

    localparam logic [AW-1:0] STEP1 = AW'(ISZ);
    localparam logic [AW-1:0] STEP2 = AW'(2 * ISZ);

    ctl_class_e    cls;
    logic [NT-1:0] acc_valid;
    logic [NT*AW-1:0] acc_tgt;
    logic [NT-1:0] run;
    logic [AW-1:0] eff   [NT];
    logic [QW-1:0] seqn  [NT];

    assign cls = classify(seq_is_ctl, seq_is_ret, seq_cond_ds, seq_pred_taken);

    fseq_squash_filter #(.NT(NT), .NSQ(NSQ), .TW(TW), .QW(QW), .AW(AW)) u_filt (
        .sqi_valid (sqi_valid),
        .sqi_tid   (sqi_tid),
        .sqi_seq   (sqi_seq),
        .sqi_tgt   (sqi_tgt),
        .acc_valid (acc_valid),
        .acc_tgt   (acc_tgt)
    );

    for (genvar t = 0; t < NT; t++) begin : g_thr
        fseq_thread #(.AW(AW), .QW(QW), .SW(SW), .ISZ(ISZ)) u_thr (
            .clk         (clk),
            .rst_n       (rst_n),
            .go          (seq_valid && (seq_tid == TW'(t))),
            .cls         (cls),
            .stage       (seq_stage),
            .ptgt_in     (seq_pred_tgt),
            .act         (act_valid && (act_tid == TW'(t))),
            .act_pc      (act_pc),
            .deact       (deact_valid && (deact_tid == TW'(t))),
            .sq_acc      (acc_valid[t]),
            .sq_tgt      (acc_tgt[t*AW +: AW]),
            .run         (run[t]),
            .eff_pc      (eff[t]),
            .seq_no      (seqn[t]),
            .unblk       (unblk_valid[t]),
            .unblk_stage (unblk_stage[t*SW +: SW])
        );
    end

    always_comb begin
        rsp_done     = seq_valid && run[seq_tid];
        rsp_addr     = eff[seq_tid];
        rsp_npc      = eff[seq_tid] + STEP1;
        rsp_nnpc     = eff[seq_tid] + STEP2;
        rsp_ptgt     = eff[seq_tid] + STEP2;
        rsp_seq      = seqn[seq_tid];
        sq_out_valid = 1'b0;
        sq_out_seq   = '0;
        sq_out_tgt   = '0;
        blk_valid    = 1'b0;
        blk_stage    = '0;
        if (rsp_done) begin
            unique case (cls)
                CT_TAKEN: begin
                    sq_out_valid = 1'b1;
                    sq_out_seq   = rsp_seq + 1'b1;
                    sq_out_tgt   = seq_pred_tgt;
                end
                CT_COND_SKIP: begin
                    sq_out_valid = 1'b1;
                    sq_out_seq   = rsp_seq;
                    sq_out_tgt   = rsp_nnpc;
                end
                CT_RET_BLOCK: begin
                    blk_valid = 1'b1;
                    blk_stage = seq_stage;
                end
                CT_NONE, CT_NT_PLAIN: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int AW  = 32,
    parameter int QW  = 16,
    parameter int SW  = 3,
    parameter int NT  = 2,
    parameter int NSQ = 2,
    parameter int ISZ = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           seq_valid,
    input logic           seq_is_ctl,
    input logic           seq_is_ret,
    input logic           seq_cond_ds,
    input logic           seq_pred_taken,
    input logic [AW-1:0]  seq_pred_tgt,
    input logic [SW-1:0]  seq_stage,
    input logic           rsp_done,
    input logic [AW-1:0]  rsp_addr,
    input logic [AW-1:0]  rsp_npc,
    input logic [AW-1:0]  rsp_nnpc,
    input logic [QW-1:0]  rsp_seq,
    input logic           sq_out_valid,
    input logic [QW-1:0]  sq_out_seq,
    input logic [AW-1:0]  sq_out_tgt,
    input logic           blk_valid,
    input logic [SW-1:0]  blk_stage,
    input logic [NSQ-1:0] sqi_valid,
    input logic [NT-1:0]  unblk_valid
);

    p_done_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> seq_valid);

    p_addr_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_npc == rsp_addr + AW'(ISZ)) && (rsp_nnpc == rsp_addr + AW'(2 * ISZ)));

    p_taken_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && seq_is_ctl && seq_pred_taken) |->
            (sq_out_valid && (sq_out_seq == rsp_seq + 1'b1) && (sq_out_tgt == seq_pred_tgt)));

    p_cond_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && seq_is_ctl && seq_cond_ds && !seq_is_ret && !seq_pred_taken) |->
            (sq_out_valid && (sq_out_seq == rsp_seq) && (sq_out_tgt == rsp_addr + AW'(2 * ISZ))));

    p_nonctl_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_is_ctl |-> (!sq_out_valid && !blk_valid));

    p_block_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> (rsp_done && seq_is_ret && !seq_pred_taken && (blk_stage == seq_stage)));

    p_release_needs_squash_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(unblk_valid) != 0) |-> ($countones(sqi_valid) != 0));

endmodule

bind fseq_core fseq_chk #(
    .AW(AW), .QW(QW), .SW(SW), .NT(NT), .NSQ(NSQ), .ISZ(ISZ)
) u_fseq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .seq_valid      (seq_valid),
    .seq_is_ctl     (seq_is_ctl),
    .seq_is_ret     (seq_is_ret),
    .seq_cond_ds    (seq_cond_ds),
    .seq_pred_taken (seq_pred_taken),
    .seq_pred_tgt   (seq_pred_tgt),
    .seq_stage      (seq_stage),
    .rsp_done       (rsp_done),
    .rsp_addr       (rsp_addr),
    .rsp_npc        (rsp_npc),
    .rsp_nnpc       (rsp_nnpc),
    .rsp_seq        (rsp_seq),
    .sq_out_valid   (sq_out_valid),
    .sq_out_seq     (sq_out_seq),
    .sq_out_tgt     (sq_out_tgt),
    .blk_valid      (blk_valid),
    .blk_stage      (blk_stage),
    .sqi_valid      (sqi_valid),
    .unblk_valid    (unblk_valid)
);

// File: tb/tb_fseq_core.sv
module tb_fseq_core;

    localparam int CLK_P = 10;
    localparam int AW = 32, QW = 16, SW = 3, NT = 2, NSQ = 2, TW = 1;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              seq_valid, seq_is_ctl, seq_is_ret, seq_cond_ds, seq_pred_taken;
    logic [TW-1:0]     seq_tid;
    logic [SW-1:0]     seq_stage;
    logic [AW-1:0]     seq_pred_tgt;
    logic              rsp_done, sq_out_valid, blk_valid;
    logic [AW-1:0]     rsp_addr, rsp_npc, rsp_nnpc, rsp_ptgt, sq_out_tgt;
    logic [QW-1:0]     rsp_seq, sq_out_seq;
    logic [SW-1:0]     blk_stage;
    logic [NSQ-1:0]    sqi_valid;
    logic [NSQ*TW-1:0] sqi_tid;
    logic [NSQ*QW-1:0] sqi_seq;
    logic [NSQ*AW-1:0] sqi_tgt;
    logic [NT-1:0]     unblk_valid;
    logic [NT*SW-1:0]  unblk_stage;
    logic              act_valid, deact_valid;
    logic [TW-1:0]     act_tid, deact_tid;
    logic [AW-1:0]     act_pc;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fseq_core dut (.*);

    // vector: tid, ctl, ret, cond, taken, ptgt, exp addr, exp seq, exp sq valid, exp sq seq, exp sq tgt
    typedef struct packed {
        logic          tid;
        logic          ctl;
        logic          ret;
        logic          cond;
        logic          tk;
        logic [31:0]   ptgt;
        logic [31:0]   eaddr;
        logic [15:0]   eseq;
        logic          esqv;
        logic [15:0]   esqs;
        logic [31:0]   esqt;
    } vec_t;

    localparam vec_t TBL [16] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h100, 16'd0, 1'b0, 16'd0, 32'h0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h800, 16'd0, 1'b0, 16'd0, 32'h0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h200, 32'h104, 16'd1, 1'b1, 16'd2, 32'h200},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h108, 16'd2, 1'b0, 16'd0, 32'h0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h804, 16'd1, 1'b0, 16'd0, 32'h0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h200, 16'd3, 1'b0, 16'd0, 32'h0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,   32'h204, 16'd4, 1'b0, 16'd0, 32'h0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h208, 16'd5, 1'b0, 16'd0, 32'h0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h20C, 16'd6, 1'b0, 16'd0, 32'h0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,   32'h210, 16'd7, 1'b1, 16'd7, 32'h218},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h214, 16'd8, 1'b0, 16'd0, 32'h0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h990, 32'h808, 16'd2, 1'b0, 16'd0, 32'h0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h80C, 16'd3, 1'b0, 16'd0, 32'h0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h900, 32'h810, 16'd4, 1'b1, 16'd5, 32'h900},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h814, 16'd5, 1'b0, 16'd0, 32'h0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h900, 16'd6, 1'b0, 16'd0, 32'h0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic begin_cycle();
        @(negedge clk);
        seq_valid = 0; seq_tid = 0; seq_stage = 0; seq_is_ctl = 0; seq_is_ret = 0;
        seq_cond_ds = 0; seq_pred_taken = 0; seq_pred_tgt = 0;
        sqi_valid = 0; sqi_tid = 0; sqi_seq = 0; sqi_tgt = 0;
        act_valid = 0; act_tid = 0; act_pc = 0; deact_valid = 0; deact_tid = 0;
    endtask

    task automatic set_sq(input int p, input logic tid, input logic [15:0] s, input logic [31:0] tgt);
        sqi_valid[p]          = 1'b1;
        sqi_tid[p]            = tid;
        sqi_seq[p*QW +: QW]   = s;
        sqi_tgt[p*AW +: AW]   = tgt;
    endtask

    task automatic set_seq(input logic tid, input logic ctl, input logic ret, input logic cond,
                           input logic tk, input logic [31:0] ptgt, input logic [2:0] stg);
        seq_valid = 1; seq_tid = tid; seq_is_ctl = ctl; seq_is_ret = ret;
        seq_cond_ds = cond; seq_pred_taken = tk; seq_pred_tgt = ptgt; seq_stage = stg;
    endtask

    // plain sequencing step with address/number check
    task automatic fetch_chk(input string req, input logic tid, input logic [31:0] ea, input logic [15:0] es);
        begin_cycle();
        set_seq(tid, 0, 0, 0, 0, 0, 0);
        #1;
        chk({req, " done"}, 64'(rsp_done), 64'd1);
        chk({req, " addr"}, 64'(rsp_addr), 64'(ea));
        chk({req, " seq"},  64'(rsp_seq),  64'(es));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        begin_cycle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: inactive after reset
        for (int t = 0; t < NT; t++) begin
            begin_cycle();
            set_seq(1'(t), 1, 0, 0, 1, 32'h44, 0);
            #1;
            chk("R1 done after reset", 64'(rsp_done), 64'd0);
            chk("R1 no squash", 64'(sq_out_valid), 64'd0);
            chk("R1 no block", 64'(blk_valid), 64'd0);
        end

        // R12: activate both threads
        begin_cycle(); act_valid = 1; act_tid = 0; act_pc = 32'h100;
        begin_cycle(); act_valid = 1; act_tid = 1; act_pc = 32'h800;

        // table walk: R2 sequential, R3 taken, R4 plain not taken, R5 cond skip, R6 non-control
        for (int i = 0; i < 16; i++) begin
            begin_cycle();
            set_seq(TBL[i].tid, TBL[i].ctl, TBL[i].ret, TBL[i].cond, TBL[i].tk, TBL[i].ptgt, 0);
            #1;
            chk($sformatf("R2 v%0d done", i), 64'(rsp_done), 64'd1);
            chk($sformatf("R2/R3/R4/R6 v%0d addr", i), 64'(rsp_addr), 64'(TBL[i].eaddr));
            chk($sformatf("R2 v%0d npc", i), 64'(rsp_npc), 64'(TBL[i].eaddr + 32'd4));
            chk($sformatf("R2 v%0d nnpc", i), 64'(rsp_nnpc), 64'(TBL[i].eaddr + 32'd8));
            chk($sformatf("R2 v%0d ptgt", i), 64'(rsp_ptgt), 64'(TBL[i].eaddr + 32'd8));
            chk($sformatf("R2 v%0d seq", i), 64'(rsp_seq), 64'(TBL[i].eseq));
            chk($sformatf("R3/R5/R6 v%0d sq valid", i), 64'(sq_out_valid), 64'(TBL[i].esqv));
            if (TBL[i].esqv) begin
                chk($sformatf("R3/R5 v%0d sq seq", i), 64'(sq_out_seq), 64'(TBL[i].esqs));
                chk($sformatf("R3/R5 v%0d sq tgt", i), 64'(sq_out_tgt), 64'(TBL[i].esqt));
            end
            chk($sformatf("R6 v%0d no block", i), 64'(blk_valid), 64'd0);
        end

        // R9: same-cycle squash filter on thread 0 (next t0 seq 9)
        begin_cycle(); set_sq(0, 0, 16'd20, 32'h300); set_sq(1, 0, 16'd15, 32'h400);
        fetch_chk("R9 older port1 wins", 0, 32'h400, 16'd9);
        begin_cycle(); set_sq(0, 0, 16'd30, 32'h500); set_sq(1, 0, 16'd30, 32'h600);
        fetch_chk("R9 tie lower port", 0, 32'h500, 16'd10);
        begin_cycle(); set_sq(0, 0, 16'd10, 32'h700); set_sq(1, 0, 16'd12, 32'h780);
        fetch_chk("R9 younger port1 ignored", 0, 32'h700, 16'd11);
        begin_cycle(); set_sq(0, 0, 16'd50, 32'h1100); set_sq(1, 1, 16'd40, 32'h1200);
        fetch_chk("R9 t0 separate thread", 0, 32'h1100, 16'd12);
        fetch_chk("R9 t1 separate thread", 1, 32'h1200, 16'd7);

        // R11: request and squash on thread 1 in one cycle
        begin_cycle();
        set_seq(1, 0, 0, 0, 0, 0, 0);
        set_sq(0, 1, 16'd3, 32'hA00);
        #1;
        chk("R11 pre-squash addr", 64'(rsp_addr), 64'h1204);
        chk("R11 seq", 64'(rsp_seq), 64'd8);
        fetch_chk("R11 squash target wins", 1, 32'hA00, 16'd9);

        // R8: squash drops a pending delayed redirect
        begin_cycle(); set_seq(1, 1, 0, 0, 1, 32'hB00, 0);
        begin_cycle(); set_sq(1, 1, 16'd5, 32'hC00);
        fetch_chk("R8 redirect", 1, 32'hC00, 16'd11);
        fetch_chk("R8 pending dropped", 1, 32'hC04, 16'd12);

        // R7: blocking return on thread 0
        begin_cycle();
        set_seq(0, 1, 1, 0, 0, 0, 3'd3);
        #1;
        chk("R7 return done", 64'(rsp_done), 64'd1);
        chk("R7 blk_valid", 64'(blk_valid), 64'd1);
        chk("R7 blk_stage", 64'(blk_stage), 64'd3);
        chk("R7 no squash", 64'(sq_out_valid), 64'd0);
        begin_cycle(); set_seq(0, 0, 0, 0, 0, 0, 0); #1;
        chk("R7 stall while blocked", 64'(rsp_done), 64'd0);
        fetch_chk("R7 other thread runs", 1, 32'hC08, 16'd13);

        // R10: squash releases the blocked stage
        begin_cycle(); set_sq(0, 0, 16'd14, 32'hD00); #1;
        chk("R10 unblk_valid", 64'(unblk_valid), 64'b01);
        chk("R10 unblk_stage", 64'(unblk_stage[SW-1:0]), 64'd3);
        fetch_chk("R10/R7 resumes, no seq used by stall", 0, 32'hD00, 16'd14);

        // R11: blocking return and squash in the same cycle
        begin_cycle();
        set_seq(0, 1, 1, 0, 0, 0, 3'd5);
        set_sq(1, 0, 16'd2, 32'hE00);
        #1;
        chk("R11 block raised", 64'(blk_valid), 64'd1);
        chk("R11 same-cycle release", 64'(unblk_valid), 64'b01);
        chk("R11 release stage", 64'(unblk_stage[SW-1:0]), 64'd5);
        chk("R11 ret addr", 64'(rsp_addr), 64'hD04);
        fetch_chk("R11 no lingering block", 0, 32'hE00, 16'd16);

        // R12: deactivate with a pending redirect, then reactivate
        begin_cycle(); set_seq(1, 1, 0, 0, 1, 32'h1000, 0);
        begin_cycle(); deact_valid = 1; deact_tid = 1;
        begin_cycle(); set_seq(1, 0, 0, 0, 0, 0, 0); #1;
        chk("R12 deactivated stalls", 64'(rsp_done), 64'd0);
        fetch_chk("R12 t0 unaffected", 0, 32'hE04, 16'd17);
        begin_cycle(); act_valid = 1; act_tid = 1; act_pc = 32'hF00;
        fetch_chk("R12 activate pc", 1, 32'hF00, 16'd15);
        fetch_chk("R12 record cleared", 1, 32'hF04, 16'd16);

        begin_cycle();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule